// File: doc/BRIEF.md
# Nibble-wide DRAM access sequencer

This block performs byte accesses to a dynamic RAM whose data path is only four bits wide. Time is cut into fixed slots of eight clock cycles (500 ns at the nominal 16 MHz clock). Each slot that has an owner carries one complete byte access. The row strobe is lowered once, and the column strobe is lowered twice, with a new column address each time, so the two halves of the byte move one after the other in page-mode fashion. Row and column addresses share one narrow multiplexed address bus. The write strobe is held low for writes and high for reads.

Every slot is given in advance to the video fetcher, to the CPU, or to nobody. A two-bit bandwidth mode and a display-active flag set the policy. With no display traffic, every slot is open to the CPU. In the shared mode, video takes every other slot while a line is displayed. In the full-video modes, video takes every slot while a line is displayed and the CPU waits. A CPU request is held with a wait signal until a CPU slot serves it. Completion is marked by a one-cycle pulse in the last cycle of the slot.

Top module: `nibble_dram_seq`

## Requirements
- R1: While reset is held and until the first owned slot, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high and `vid_valid` and `cpu_ready` are low.
- R2: A slot is 8 cycles, numbered 0 to 7. In an owned slot, `dram_ras_n` is low in cycles 0 to 5 only, and `dram_cas_n` is low in cycles 1-2 and 4-5 only. That gives one row strobe fall and two column strobe falls per access.
- R3: For byte address A (15 bits), the bus carries the row A[14:7] in the cycle before the row strobe falls and in the cycle it falls. The first column {A[6:0],0} is on the bus while the first column strobe is low. The bus switches to the second column {A[6:0],1} while the column strobe is high, and holds it through the second pulse.
- R4: The nibble transferred under the first column strobe is byte bits [3:0], and the one under the second is bits [7:4]. This holds for reads and for writes (`dram_dq_out`, with `dram_dq_oe` high).
- R5: `dram_we_n` is low at both column strobe falls of a write, and high throughout a read.
- R6: `rd_data` holds the assembled byte while `vid_valid` (video slot) or `cpu_ready` (CPU slot, read or write) is high. Each of these is a single-cycle pulse in cycle 7 of the slot that did the access.
- R7: `bw_mode` sets slot ownership. 2'b00 gives every slot to the CPU and ignores `disp_active`. With `disp_active` high, 2'b01 gives every other slot to video, and 2'b10 or 2'b11 gives every slot to video. With `disp_active` low, no slot goes to video in any mode.
- R8: A CPU request raised during video-owned slots is not served, and `cpu_wait` stays high until a CPU-owned slot completes it. A request that its own slot is completing is not granted a second slot.
- R9: A slot with no owner produces no row or column strobe.
- R10: A video slot reads the byte at `vid_addr` as sampled when the slot was assigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, one cycle per eighth of a slot |
| rst_n | input | 1 | Active-low synchronous reset |
| bw_mode | input | 2 | Slot-sharing policy (see R7) |
| disp_active | input | 1 | High while a display line needs fetches |
| vid_addr | input | 15 | Byte address for the next video fetch |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 15 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| dram_dq_in | input | 4 | Nibble read from the RAM |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_ma | output | 8 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Nibble driven to the RAM on writes |
| dram_dq_oe | output | 1 | High while `dram_dq_out` should drive the RAM |
| rd_data | output | 8 | Assembled read byte |
| vid_valid | output | 1 | Video fetch complete, `rd_data` valid |
| cpu_ready | output | 1 | CPU access complete, `rd_data` valid for reads |
| cpu_wait | output | 1 | CPU request pending and not yet served |

## Verification
A slip in the phase count shows within a single slot: the strobe pulses move away from their fixed cycles, or the completion pulse leaves cycle 7. A corrupted owner or pending-slot register shows at the end of the affected slot. The pulse comes on the wrong output, or the row and columns seen on the bus do not match the requester's address. If the nibbles are swapped or captured in the wrong cycle, `rd_data` is wrong at the pulse of that same slot. An arbitration fault shows as a broken spacing between video pulses (8 or 16 cycles), or as a CPU completion inside a window reserved for video.

// File: rtl/nds_pkg.sv
package nds_pkg;

    // Who carries the access in a slot
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_VID  = 2'd1,
        OWN_CPU  = 2'd2
    } owner_e;

    // Bandwidth policy selected by the display side
    typedef enum logic [1:0] {
        BW_CPU_ONLY  = 2'd0,
        BW_SHARED    = 2'd1,
        BW_VIDEO     = 2'd2,
        BW_VIDEO_ALT = 2'd3
    } bw_mode_e;

    // Slot grid: fixed by the strobe protocol, eight cycles per access
    localparam int unsigned PH_W       = 3;
    localparam logic [2:0] PH_FIRST    = 3'd0;
    localparam logic [2:0] PH_LO_TAKE  = 3'd2;
    localparam logic [2:0] PH_COL_SWAP = 3'd3;
    localparam logic [2:0] PH_HI_TAKE  = 3'd5;
    localparam logic [2:0] PH_DECIDE   = 3'd6;
    localparam logic [2:0] PH_LAST     = 3'd7;

    function automatic logic row_strobe_low(input logic [2:0] ph);
        return ph <= PH_HI_TAKE;
    endfunction

    function automatic logic col_strobe_low(input logic [2:0] ph);
        return (ph == 3'd1) || (ph == 3'd2) || (ph == 3'd4) || (ph == 3'd5);
    endfunction

endpackage

// File: rtl/nds_slot_timer.sv
module nds_slot_timer
    import nds_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase_o,
    output logic            par_o
);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            par;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d       = tmr_q;
        tmr_d.phase = tmr_q.phase + 3'd1;
        if (tmr_q.phase == PH_LAST) begin
            tmr_d.par = ~tmr_q.par;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign phase_o = tmr_q.phase;
    assign par_o   = tmr_q.par;

    // R2: the slot grid never skips or stalls
    a_r2_phase_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.phase == PH_LAST) |=> (tmr_q.phase == PH_FIRST));
    a_r2_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.phase != PH_LAST) |=> (tmr_q.phase == $past(tmr_q.phase) + 3'd1));

endmodule

// File: rtl/nds_slot_arbiter.sv
module nds_slot_arbiter
    import nds_pkg::*;
#(
    parameter int BA_W   = 15,
    parameter int BYTE_W = 8
) (
    input  bw_mode_e          mode_i,
    input  logic              disp_active_i,
    input  logic              next_par_i,
    input  logic              cpu_busy_i,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [BA_W-1:0]   cpu_addr_i,
    input  logic [BYTE_W-1:0] cpu_wdata_i,
    input  logic [BA_W-1:0]   vid_addr_i,
    output owner_e            owner_o,
    output logic              we_o,
    output logic [BA_W-1:0]   addr_o,
    output logic [BYTE_W-1:0] wdata_o
);

    logic vid_claims;

    always_comb begin
        unique case (mode_i)
            BW_CPU_ONLY:  vid_claims = 1'b0;
            BW_SHARED:    vid_claims = disp_active_i && !next_par_i;
            default:      vid_claims = disp_active_i;
        endcase
    end

    always_comb begin
        owner_o = OWN_NONE;
        we_o    = 1'b0;
        addr_o  = '0;
        wdata_o = '0;
        if (vid_claims) begin
            owner_o = OWN_VID;
            addr_o  = vid_addr_i;
        end else if (cpu_req_i && !cpu_busy_i) begin
            // a request finishing in the current slot is not granted again
            owner_o = OWN_CPU;
            we_o    = cpu_we_i;
            addr_o  = cpu_addr_i;
            wdata_o = cpu_wdata_i;
        end
    end

endmodule

// File: rtl/nds_access_engine.sv
module nds_access_engine
    import nds_pkg::*;
#(
    parameter  int MA_W   = 8,
    parameter  int DQ_W   = 4,
    localparam int BA_W   = 2 * MA_W - 1,
    localparam int BYTE_W = 2 * DQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase_i,
    input  owner_e            arb_owner_i,
    input  logic              arb_we_i,
    input  logic [BA_W-1:0]   arb_addr_i,
    input  logic [BYTE_W-1:0] arb_wdata_i,
    input  logic [DQ_W-1:0]   dq_in_i,
    output logic              cur_is_cpu_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [MA_W-1:0]   ma_o,
    output logic [DQ_W-1:0]   dq_out_o,
    output logic              dq_oe_o,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              vid_valid_o,
    output logic              cpu_ready_o
);

    typedef struct packed {
        owner_e            owner;
        logic              we;
        logic [BA_W-1:0]   addr;
        logic [BYTE_W-1:0] wdata;
    } slot_t;

    typedef struct packed {
        slot_t             cur;
        slot_t             nxt;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [MA_W-1:0]   ma;
        logic [DQ_W-1:0]   dq;
        logic              dq_oe;
        logic [DQ_W-1:0]   lo_nib;
        logic [BYTE_W-1:0] rdata;
        logic              vid_valid;
        logic              cpu_ready;
    } eng_t;

    function automatic logic [MA_W-1:0] row_of(input logic [BA_W-1:0] a);
        return a[BA_W-1 -: MA_W];
    endfunction

    function automatic logic [MA_W-1:0] col_of(input logic [BA_W-1:0] a, input logic hi);
        return {a[MA_W-2:0], hi};
    endfunction

    eng_t            eng_q, eng_d;
    logic [PH_W-1:0] ph_next;
    slot_t           drive_slot;
    slot_t           arb_slot;
    logic            drive_act;
    logic            cur_reads;

    always_comb begin
        arb_slot.owner = arb_owner_i;
        arb_slot.we    = arb_we_i;
        arb_slot.addr  = arb_addr_i;
        arb_slot.wdata = arb_wdata_i;
    end

    always_comb begin
        eng_d           = eng_q;
        eng_d.vid_valid = 1'b0;
        eng_d.cpu_ready = 1'b0;

        ph_next    = phase_i + 3'd1;
        // the slot whose pins are driven in the coming cycle
        drive_slot = (phase_i == PH_LAST) ? eng_q.nxt : eng_q.cur;
        drive_act  = (drive_slot.owner != OWN_NONE);
        cur_reads  = (eng_q.cur.owner != OWN_NONE) && !eng_q.cur.we;

        // strobes for the coming cycle
        eng_d.ras_n = !(drive_act && row_strobe_low(ph_next));
        eng_d.cas_n = !(drive_act && col_strobe_low(ph_next));
        eng_d.we_n  = !(drive_act && drive_slot.we && row_strobe_low(ph_next));
        eng_d.dq_oe = drive_act && drive_slot.we && row_strobe_low(ph_next);
        eng_d.dq    = (ph_next < PH_COL_SWAP) ? drive_slot.wdata[DQ_W-1:0]
                                              : drive_slot.wdata[BYTE_W-1:DQ_W];

        // multiplexed address: row a cycle early, then the two columns
        if (ph_next == PH_LAST) begin
            eng_d.ma = (arb_owner_i != OWN_NONE) ? row_of(arb_addr_i) : '0;
        end else if (!drive_act) begin
            eng_d.ma = '0;
        end else if (ph_next == PH_FIRST) begin
            eng_d.ma = row_of(drive_slot.addr);
        end else if (ph_next < PH_COL_SWAP) begin
            eng_d.ma = col_of(drive_slot.addr, 1'b0);
        end else begin
            eng_d.ma = col_of(drive_slot.addr, 1'b1);
        end

        // read capture: low nibble first, high nibble second
        if (phase_i == PH_LO_TAKE && cur_reads) begin
            eng_d.lo_nib = dq_in_i;
        end
        if (phase_i == PH_HI_TAKE && cur_reads) begin
            eng_d.rdata = {dq_in_i, eng_q.lo_nib};
        end

        // ownership pipeline and completion pulses
        if (phase_i == PH_DECIDE) begin
            eng_d.nxt       = arb_slot;
            eng_d.vid_valid = (eng_q.cur.owner == OWN_VID);
            eng_d.cpu_ready = (eng_q.cur.owner == OWN_CPU);
        end
        if (phase_i == PH_LAST) begin
            eng_d.cur       = eng_q.nxt;
            eng_d.nxt       = '0;
            eng_d.nxt.owner = OWN_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q           <= '0;
            eng_q.cur.owner <= OWN_NONE;
            eng_q.nxt.owner <= OWN_NONE;
            eng_q.ras_n     <= 1'b1;
            eng_q.cas_n     <= 1'b1;
            eng_q.we_n      <= 1'b1;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign cur_is_cpu_o = (eng_q.cur.owner == OWN_CPU);
    assign ras_n_o      = eng_q.ras_n;
    assign cas_n_o      = eng_q.cas_n;
    assign we_n_o       = eng_q.we_n;
    assign ma_o         = eng_q.ma;
    assign dq_out_o     = eng_q.dq;
    assign dq_oe_o      = eng_q.dq_oe;
    assign rd_data_o    = eng_q.rdata;
    assign vid_valid_o  = eng_q.vid_valid;
    assign cpu_ready_o  = eng_q.cpu_ready;

    // R2: column strobes only under an open row
    a_r2_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_q.cas_n |-> !eng_q.ras_n);
    // R2: the row opens only at the start of the slot grid
    a_r2_ras_falls_at_slot_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_q.ras_n) |-> (phase_i == PH_FIRST));
    // R3: the row address does not move across the row strobe fall
    a_r3_row_held: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eng_q.ras_n) |-> $stable(eng_q.ma));
    // R5: write strobe only inside an open row
    a_r5_we_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_q.we_n |-> !eng_q.ras_n);
    // R6: completion pulses are exclusive, single-cycle, and at the slot end
    a_r6_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eng_q.vid_valid, eng_q.cpu_ready}));
    a_r6_pulse_at_last_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.vid_valid || eng_q.cpu_ready) |-> (phase_i == PH_LAST));
    a_r6_vid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.vid_valid |=> !eng_q.vid_valid);

endmodule

// File: rtl/nibble_dram_seq.sv
module nibble_dram_seq
    import nds_pkg::*;
#(
    parameter  int MA_W   = 8,
    parameter  int DQ_W   = 4,
    localparam int BA_W   = 2 * MA_W - 1,
    localparam int BYTE_W = 2 * DQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bw_mode,
    input  logic              disp_active,
    input  logic [BA_W-1:0]   vid_addr,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [BA_W-1:0]   cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    input  logic [DQ_W-1:0]   dram_dq_in,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [MA_W-1:0]   dram_ma,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    output logic [BYTE_W-1:0] rd_data,
    output logic              vid_valid,
    output logic              cpu_ready,
    output logic              cpu_wait
);

    logic [PH_W-1:0]   phase;
    logic              par;
    logic              cur_is_cpu;
    owner_e            arb_owner;
    logic              arb_we;
    logic [BA_W-1:0]   arb_addr;
    logic [BYTE_W-1:0] arb_wdata;

    nds_slot_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase),
        .par_o   (par)
    );

    nds_slot_arbiter #(
        .BA_W   (BA_W),
        .BYTE_W (BYTE_W)
    ) u_arbiter (
        .mode_i        (bw_mode_e'(bw_mode)),
        .disp_active_i (disp_active),
        .next_par_i    (~par),
        .cpu_busy_i    (cur_is_cpu),
        .cpu_req_i     (cpu_req),
        .cpu_we_i      (cpu_we),
        .cpu_addr_i    (cpu_addr),
        .cpu_wdata_i   (cpu_wdata),
        .vid_addr_i    (vid_addr),
        .owner_o       (arb_owner),
        .we_o          (arb_we),
        .addr_o        (arb_addr),
        .wdata_o       (arb_wdata)
    );

    nds_access_engine #(
        .MA_W (MA_W),
        .DQ_W (DQ_W)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_i      (phase),
        .arb_owner_i  (arb_owner),
        .arb_we_i     (arb_we),
        .arb_addr_i   (arb_addr),
        .arb_wdata_i  (arb_wdata),
        .dq_in_i      (dram_dq_in),
        .cur_is_cpu_o (cur_is_cpu),
        .ras_n_o      (dram_ras_n),
        .cas_n_o      (dram_cas_n),
        .we_n_o       (dram_we_n),
        .ma_o         (dram_ma),
        .dq_out_o     (dram_dq_out),
        .dq_oe_o      (dram_dq_oe),
        .rd_data_o    (rd_data),
        .vid_valid_o  (vid_valid),
        .cpu_ready_o  (cpu_ready)
    );

    assign cpu_wait = cpu_req && !cpu_ready;

    // R8: a CPU completion only closes a slot granted to the CPU
    a_r8_ready_from_cpu_slot: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> $past(cur_is_cpu));

endmodule

// File: tb/nibble_dram_seq_tb.sv
module nibble_dram_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  bw_mode;
    logic        disp_active;
    logic [14:0] vid_addr;
    logic        cpu_req;
    logic        cpu_we;
    logic [14:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic [3:0]  dram_dq_in;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [7:0]  dram_ma;
    logic [3:0]  dram_dq_out;
    logic [7:0]  rd_data;
    logic        vid_valid, cpu_ready, cpu_wait;

    always #2 clk = ~clk;

    nibble_dram_seq u_dut (
        .clk(clk), .rst_n(rst_n), .bw_mode(bw_mode), .disp_active(disp_active),
        .vid_addr(vid_addr), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .dram_dq_in(dram_dq_in), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_ma(dram_ma),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .rd_data(rd_data),
        .vid_valid(vid_valid), .cpu_ready(cpu_ready), .cpu_wait(cpu_wait)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural nibble RAM and byte-level reference
    logic [3:0] nib_mem [int unsigned];
    logic [7:0] ref_mem [int unsigned];

    function automatic logic [7:0] ref_byte(input logic [14:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    task automatic preload(input logic [14:0] a, input logic [7:0] b);
        nib_mem[int'({a, 1'b0})] = b[3:0];
        nib_mem[int'({a, 1'b1})] = b[7:4];
        ref_mem[int'(a)] = b;
    endtask

    typedef struct {
        bit          we;
        logic [14:0] addr;
        logic [7:0]  data;
    } exp_t;
    exp_t exp_q[$];

    // monitor state
    int          cyc = 0;
    logic        ras_p = 1'b1, cas_p = 1'b1;
    logic [7:0]  ma_p = '0;
    logic [7:0]  row_l = '0, col_l = '0;
    int          ras_low_n = 0, cas_low_n = 0, ras_falls = 0, cas_falls = 0, we_low_falls = 0;
    logic [7:0]  seen_row = '0, seen_c0 = '0, seen_c1 = '0;
    bit          row_early_ok = 1'b1;
    int          last_vid = -1;
    int          exp_vid_gap = 0;
    int          vid_cnt = 0;
    bit          forbid_vid = 1'b0;
    bit          forbid_cpu = 1'b0;
    int          strobe_seen = 0;

    task automatic check_slot(input string who, input bit we, input logic [14:0] a);
        check(ras_falls == 1, "R2", {who, " row strobe falls"}, ras_falls, 1);
        check(cas_falls == 2, "R2", {who, " column strobe falls"}, cas_falls, 2);
        check(ras_low_n == 6, "R2", {who, " row strobe low cycles"}, ras_low_n, 6);
        check(cas_low_n == 4, "R2", {who, " column strobe low cycles"}, cas_low_n, 4);
        check(row_early_ok, "R3", {who, " row set before strobe"}, 0, 1);
        check(seen_row == a[14:7], "R3", {who, " row"}, seen_row, a[14:7]);
        check(seen_c0 == {a[6:0], 1'b0}, "R3", {who, " first column"}, seen_c0, {a[6:0], 1'b0});
        check(seen_c1 == {a[6:0], 1'b1}, "R3", {who, " second column"}, seen_c1, {a[6:0], 1'b1});
        check(we_low_falls == (we ? 2 : 0), "R5", {who, " write strobe at column falls"},
              we_low_falls, we ? 2 : 0);
    endtask

    always @(negedge clk) begin
        cyc++;
        // DRAM model: latch on strobe falls, write early, drive read nibble
        if (!dram_ras_n && ras_p) begin
            row_l = dram_ma;
            seen_row = dram_ma;
            ras_falls++;
            if (dram_ma != ma_p) row_early_ok = 1'b0;
        end
        if (!dram_cas_n && cas_p) begin
            col_l = dram_ma;
            if (cas_falls == 0) seen_c0 = dram_ma; else seen_c1 = dram_ma;
            cas_falls++;
            if (!dram_we_n) begin
                we_low_falls++;
                nib_mem[int'({row_l, col_l})] = dram_dq_out;
            end
        end
        dram_dq_in = nib_mem.exists(int'({row_l, col_l})) ? nib_mem[int'({row_l, col_l})] : 4'h0;
        if (!dram_ras_n) ras_low_n++;
        if (!dram_cas_n) cas_low_n++;
        if (!dram_ras_n || !dram_cas_n) strobe_seen++;

        // scoreboard
        if (cpu_ready) begin
            check(!forbid_cpu, "R8", "CPU served in video-owned window", 1, 0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "cpu_ready with nothing pending", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check_slot("cpu", e.we, e.addr);
                if (!e.we) check(rd_data == e.data, "R4", "CPU read byte (R6 pulse)", rd_data, e.data);
            end
        end
        if (vid_valid) begin
            vid_cnt++;
            check(!forbid_vid, "R7", "video slot when none allowed", 1, 0);
            check_slot("video", 1'b0, vid_addr);
            check(rd_data == ref_byte(vid_addr), "R10", "video byte", rd_data, ref_byte(vid_addr));
            if (exp_vid_gap != 0 && last_vid >= 0)
                check(cyc - last_vid == exp_vid_gap, "R7", "video slot spacing",
                      cyc - last_vid, exp_vid_gap);
            last_vid = cyc;
        end
        if (cpu_ready || vid_valid) begin
            ras_low_n = 0; cas_low_n = 0; ras_falls = 0; cas_falls = 0;
            we_low_falls = 0; row_early_ok = 1'b1;
        end
        ras_p = dram_ras_n;
        cas_p = dram_cas_n;
        ma_p  = dram_ma;
    end

    task automatic cpu_access(input bit we, input logic [14:0] a, input logic [7:0] wd);
        exp_t e;
        e.we = we; e.addr = a; e.data = we ? wd : ref_byte(a);
        if (we) ref_mem[int'(a)] = wd;
        exp_q.push_back(e);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        do @(negedge clk); while (!cpu_ready);
        cpu_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bw_mode = 2'b00; disp_active = 1'b0; vid_addr = 15'h1234;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; dram_dq_in = '0;
        preload(15'h0000, 8'h96);
        preload(15'h7FFF, 8'hE1);
        preload(15'h1234, 8'h4B);
        preload(15'h2A81, 8'hC7);
        preload(15'h5555, 8'h3D);
        repeat (4) @(negedge clk);
        // R1: quiet pins in reset
        check(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes in reset",
              {dram_ras_n, dram_cas_n, dram_we_n}, 3'b111);
        check(!vid_valid && !cpu_ready, "R1", "pulses in reset", {vid_valid, cpu_ready}, 0);
        rst_n = 1'b1;
        strobe_seen = 0;
        // R9: idle slots carry no strobes
        repeat (32) @(negedge clk);
        check(strobe_seen == 0, "R9", "strobes in idle slots", strobe_seen, 0);
        check(dram_we_n && !vid_valid && !cpu_ready, "R1", "pins after reset, idle",
              {dram_we_n, vid_valid, cpu_ready}, 3'b100);

        // R7: CPU-only mode ignores display activity; R4 nibble order on reads
        forbid_vid = 1'b1;
        disp_active = 1'b1;
        cpu_access(1'b0, 15'h0000, 8'h00);
        cpu_access(1'b0, 15'h7FFF, 8'h00);
        cpu_access(1'b0, 15'h2A81, 8'h00);
        cpu_access(1'b0, 15'h5555, 8'h00);
        // R4/R5: writes land low nibble first
        cpu_access(1'b1, 15'h4000, 8'hA3);
        check(nib_mem[int'({15'h4000, 1'b0})] == 4'h3, "R4", "written low nibble",
              nib_mem[int'({15'h4000, 1'b0})], 4'h3);
        check(nib_mem[int'({15'h4000, 1'b1})] == 4'hA, "R4", "written high nibble",
              nib_mem[int'({15'h4000, 1'b1})], 4'hA);
        cpu_access(1'b0, 15'h4000, 8'h00);
        cpu_access(1'b1, 15'h0081, 8'h5C);
        cpu_access(1'b0, 15'h0081, 8'h00);

        // R7: full-video mode with display idle gives no video slots
        disp_active = 1'b0;
        bw_mode = 2'b10;
        cpu_access(1'b0, 15'h1234, 8'h00);
        cpu_access(1'b1, 15'h6F0E, 8'h81);
        cpu_access(1'b0, 15'h6F0E, 8'h00);
        forbid_vid = 1'b0;

        // R7: shared mode alternates video and CPU slots
        bw_mode = 2'b01;
        disp_active = 1'b1;
        repeat (16) @(negedge clk);
        last_vid = -1; exp_vid_gap = 16; vid_cnt = 0;
        cpu_access(1'b0, 15'h7FFF, 8'h00);
        cpu_access(1'b1, 15'h3333, 8'h29);
        cpu_access(1'b0, 15'h3333, 8'h00);
        repeat (32) @(negedge clk);
        check(vid_cnt >= 4, "R7", "video slots in shared mode", vid_cnt, 4);
        exp_vid_gap = 0;

        // R8: full-video mode stalls the CPU until display ends
        bw_mode = 2'b10;
        repeat (16) @(negedge clk);
        last_vid = -1; exp_vid_gap = 8; forbid_cpu = 1'b1;
        fork
            cpu_access(1'b0, 15'h2A81, 8'h00);
            begin
                repeat (40) @(negedge clk);
                #1;
                check(cpu_wait === 1'b1, "R8", "cpu_wait during video slots", cpu_wait, 1);
                forbid_cpu = 1'b0;
                exp_vid_gap = 0;
                disp_active = 1'b0;
            end
        join
        check(cpu_wait === 1'b0, "R8", "cpu_wait after service", cpu_wait, 0);

        // R7: the second full-video code behaves the same
        bw_mode = 2'b11;
        disp_active = 1'b1;
        repeat (16) @(negedge clk);
        vid_cnt = 0;
        repeat (40) @(negedge clk);
        check(vid_cnt == 5, "R7", "video slots in alternate full mode", vid_cnt, 5);
        disp_active = 1'b0;
        bw_mode = 2'b00;
        repeat (24) @(negedge clk);
        check(exp_q.size() == 0, "R6", "accesses left unanswered", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule